// File: doc/BRIEF.md
# Four-Channel PS/2 Receive Engine

This block is one receive shifter shared by four PS/2 device ports. Every port has an open-drain clock line and an open-drain data line. The block reads both lines and can pull the clock line low. A channel mask selects which ports may send. When at least one port is enabled, the engine releases the clock lines of the enabled ports and waits for a start bit. The first enabled port to show a start bit becomes the active port. Every other port is held off by pulling its clock low, so its device aborts the frame and sends it again later.

The engine shifts in the rest of the 11-bit frame from the active port. It checks odd parity and the stop bit, then presents the byte together with status flags: start seen, frame done, parity error, stop error, and the index of the active port. A single level interrupt combines the start and done flags, and each flag has its own mask. Each clock input passes through a synchronizer and then a debounce filter. The filter length in system clock cycles is programmable. Firmware pulses a clear input to release the held-off ports and re-arm the engine.

Top module: `ps2_rx_hub`

## Requirements
- R1: After reset, all status outputs (sot, eot, perr, ferr, irq) are 0 and every bit of ps_clk_low is 1 (mask is 0, all ports held off).
- R2: With the engine waiting for a start bit, ps_clk_low[i] equals the inverse of ch_en[i]. Enabled ports are released and disabled ports are held low.
- R3: A falling edge on an enabled port's debounced clock while its data input is low is a start bit. It sets sot to 1 and act_ch to the port index (0 to 3).
- R4: Once a port is active, no other port can take over, and ps_clk_low is 1 for every port except the active one.
- R5: If start bits arrive on several ports in the same cycle, the port with the lowest index is chosen.
- R6: The next eight clock falls on the active port carry data, least-significant bit first. After the 11th fall, eot goes to 1 and rx_data holds the byte.
- R7: The 10th fall carries parity. If the eight data bits plus the parity bit hold an even number of ones, perr is 1.
- R8: If data is low at the 11th fall, ferr is 1, and the frame still completes with eot 1 and valid rx_data.
- R9: irq is 1 when (sot AND sot_ie) OR (eot AND eot_ie) holds. It lags those flags by one cycle.
- R10: A clock-input change is accepted only after the synchronized input has differed from the accepted value for db_cycles consecutive cycles (0 is treated as 1). A shorter low pulse causes no start bit.
- R11: A one-cycle eot_clr pulse after a completed frame clears sot, eot, perr and ferr, returns the engine to waiting, and releases all enabled ports.
- R12: Setting ch_en to 0 aborts any frame in progress, clears the status flags, and holds every clock low.
- R13: A start bit on a port whose ch_en bit is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 4 | Port enable mask, bit i for port i |
| db_cycles | input | 8 | Debounce length in system cycles |
| sot_ie | input | 1 | Interrupt mask for the start flag |
| eot_ie | input | 1 | Interrupt mask for the done flag |
| eot_clr | input | 1 | One-cycle pulse that clears the done state |
| ps_clk_in | input | 4 | Sensed clock line level per port |
| ps_dat_in | input | 4 | Sensed data line level per port |
| ps_clk_low | output | 4 | 1 pulls the port's clock line low |
| sot | output | 1 | Start bit seen, transfer under way |
| eot | output | 1 | Frame complete |
| perr | output | 1 | Parity error in the last frame |
| ferr | output | 1 | Stop bit sampled low |
| act_ch | output | 2 | Index of the active port |
| rx_data | output | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
A clock-line fall at the pins reaches the status flags after db_cycles+3 system edges: two synchronizer stages, db_cycles debounce counts, and one state update. The ps_clk_low change and the irq change each come one edge later still. The bench runs its device model with half-bit periods of 12 cycles and db_cycles at 3. It samples the flags at the end of each half-bit, which is at least five cycles after every result is due. Clearing and aborting are checked four or more cycles after the input change, which exceeds the single-register path they take.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rx_state_t;

  localparam int FRAME_TAIL = 10;  // bits after the start bit
  localparam int DATA_BITS  = 8;
endpackage

// File: rtl/ps2rx_debounce.sv
module ps2rx_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic [CNT_W-1:0] limit,
  output logic             clean
);
  logic s1, s2, stab;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim_eff;
  logic [CNT_W:0]   cnt_inc;

  assign lim_eff = (limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit};
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign clean   = stab;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      stab <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == stab) begin
        cnt <= '0;
      end else if (cnt_inc >= lim_eff) begin
        stab <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  // R10
  stab_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stab) |-> stab == $past(s2));
endmodule

// File: rtl/ps2rx_core.sv
module ps2rx_core
  import ps2rx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  ch_en,
  input  logic [NCH-1:0]  clk_db,
  input  logic [NCH-1:0]  dat_s,
  input  logic            sot_ie,
  input  logic            eot_ie,
  input  logic            eot_clr,
  output logic            sot,
  output logic            eot,
  output logic            perr,
  output logic            ferr,
  output logic [CH_W-1:0] act_ch,
  output logic [7:0]      rx_data,
  output logic            irq,
  output logic [NCH-1:0]  clk_low
);
  localparam int BN_W = $clog2(FRAME_TAIL + 1);

  rx_state_t        st;
  logic [NCH-1:0]   prev;
  logic [NCH-1:0]   fall;
  logic [NCH-1:0]   start;
  logic [NCH-1:0]   sel_mask;
  logic [CH_W-1:0]  pick;
  logic [BN_W-1:0]  bitn;
  logic [7:0]       shreg;
  logic             d_act;

  assign fall     = prev & ~clk_db;
  assign start    = fall & ch_en & ~dat_s;
  assign sel_mask = NCH'(1) << act_ch;
  assign d_act    = dat_s[act_ch];

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (start[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      prev    <= '1;
      sot     <= 1'b0;
      eot     <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      act_ch  <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rx_data <= '0;
      irq     <= 1'b0;
      clk_low <= '1;
    end else begin
      prev    <= clk_db;
      irq     <= (sot & sot_ie) | (eot & eot_ie);
      clk_low <= ~ch_en | (((st == ST_RUN) || (st == ST_DONE)) ? ~sel_mask : '0);
      if (ch_en == '0) begin
        st   <= ST_OFF;
        sot  <= 1'b0;
        eot  <= 1'b0;
        perr <= 1'b0;
        ferr <= 1'b0;
      end else begin
        case (st)
          ST_OFF: st <= ST_IDLE;
          ST_IDLE: begin
            if (|start) begin
              sot    <= 1'b1;
              act_ch <= pick;
              bitn   <= '0;
              st     <= ST_RUN;
            end
          end
          ST_RUN: begin
            if (fall[act_ch]) begin
              bitn <= bitn + 1'b1;
              if (bitn < BN_W'(DATA_BITS)) begin
                shreg <= {d_act, shreg[7:1]};
              end else if (bitn == BN_W'(DATA_BITS)) begin
                perr <= ~(^shreg ^ d_act);
              end else begin
                ferr    <= ~d_act;
                rx_data <= shreg;
                eot     <= 1'b1;
                st      <= ST_DONE;
              end
            end
          end
          ST_DONE: begin
            if (eot_clr) begin
              sot  <= 1'b0;
              eot  <= 1'b0;
              perr <= 1'b0;
              ferr <= 1'b0;
              st   <= ST_IDLE;
            end
          end
          default: st <= ST_OFF;
        endcase
      end
    end
  end

  // R4
  one_port_open_chk: assert property (@(posedge clk) disable iff (rst)
    sot && $past(sot) |-> $countones(~clk_low) <= 1);
  // R6
  done_implies_start_chk: assert property (@(posedge clk) disable iff (rst)
    eot |-> sot);
  // R6
  bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitn <= BN_W'(FRAME_TAIL));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sot) && !$past(eot) |-> !irq);
  // R9
  irq_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(eot && eot_ie) |-> irq);
  // R12
  mask_abort_chk: assert property (@(posedge clk) disable iff (rst)
    ch_en == '0 |=> !sot && !eot);
endmodule

// File: rtl/ps2_rx_hub.sv
module ps2_rx_hub #(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int DB_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  ch_en,
  input  logic [DB_W-1:0] db_cycles,
  input  logic            sot_ie,
  input  logic            eot_ie,
  input  logic            eot_clr,
  input  logic [NCH-1:0]  ps_clk_in,
  input  logic [NCH-1:0]  ps_dat_in,
  output logic [NCH-1:0]  ps_clk_low,
  output logic            sot,
  output logic            eot,
  output logic            perr,
  output logic            ferr,
  output logic [CH_W-1:0] act_ch,
  output logic [7:0]      rx_data,
  output logic            irq
);
  logic [NCH-1:0] clk_db;
  logic [NCH-1:0] dat_s1, dat_s2;

  for (genvar g = 0; g < NCH; g++) begin : g_port
    ps2rx_debounce #(.CNT_W(DB_W)) u_db (
      .clk   (clk),
      .rst   (rst),
      .raw   (ps_clk_in[g]),
      .limit (db_cycles),
      .clean (clk_db[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_s1 <= '1;
      dat_s2 <= '1;
    end else begin
      dat_s1 <= ps_dat_in;
      dat_s2 <= dat_s1;
    end
  end

  ps2rx_core #(.NCH(NCH), .CH_W(CH_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .ch_en   (ch_en),
    .clk_db  (clk_db),
    .dat_s   (dat_s2),
    .sot_ie  (sot_ie),
    .eot_ie  (eot_ie),
    .eot_clr (eot_clr),
    .sot     (sot),
    .eot     (eot),
    .perr    (perr),
    .ferr    (ferr),
    .act_ch  (act_ch),
    .rx_data (rx_data),
    .irq     (irq),
    .clk_low (ps_clk_low)
  );
endmodule

// File: tb/ps2_rx_hub_tb.sv
module ps2_rx_hub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ch_en = 4'h0;
  logic [7:0] db_cycles = 8'd3;
  logic sot_ie = 1'b1, eot_ie = 1'b1, eot_clr = 1'b0;
  logic [3:0] dev_clk = 4'hF, dev_dat = 4'hF;
  logic [3:0] ps_clk_low, ln_clk;
  logic sot, eot, perr, ferr, irq;
  logic [1:0] act_ch;
  logic [7:0] rx_data;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign ln_clk = dev_clk & ~ps_clk_low;

  ps2_rx_hub dut_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .db_cycles(db_cycles),
    .sot_ie(sot_ie), .eot_ie(eot_ie), .eot_clr(eot_clr),
    .ps_clk_in(ln_clk), .ps_dat_in(dev_dat), .ps_clk_low(ps_clk_low),
    .sot(sot), .eot(eot), .perr(perr), .ferr(ferr), .act_ch(act_ch),
    .rx_data(rx_data), .irq(irq)
  );

  task automatic eqc(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitc(input int ch, input logic b);
    dev_dat[ch] = b;
    idle(H);
    dev_clk[ch] = 1'b0;
    idle(H);
    dev_clk[ch] = 1'b1;
  endtask

  function automatic logic [10:0] mkf(input logic [7:0] b, input logic badpar, input logic stop);
    return {stop, (~^b) ^ badpar, b, 1'b0};
  endfunction

  task automatic send(input int ch, input logic [10:0] f, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) bitc(ch, f[i]);
    dev_dat[ch] = 1'b1;
    idle(H);
  endtask

  task automatic clr();
    eot_clr = 1'b1;
    idle(1);
    eot_clr = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    eqc("R1 sot", sot, 0); eqc("R1 eot", eot, 0); eqc("R1 perr", perr, 0);
    eqc("R1 ferr", ferr, 0); eqc("R1 irq", irq, 0); eqc("R1 clk_low", ps_clk_low, 4'hF);
  endtask

  task automatic t_enable();
    ch_en = 4'b0101; idle(4);
    eqc("R2 partial mask", ps_clk_low, 4'b1010);
    ch_en = 4'hF; idle(4);
    eqc("R2 full mask", ps_clk_low, 4'h0);
  endtask

  task automatic t_good_frame();
    logic [10:0] f = mkf(8'hA5, 0, 1);
    send(1, f, 0, 0);
    eqc("R3 sot", sot, 1); eqc("R3 act_ch", act_ch, 1);
    eqc("R4 others held", ps_clk_low, 4'b1101);
    send(1, f, 1, 10);
    eqc("R6 eot", eot, 1); eqc("R6 data", rx_data, 8'hA5);
    eqc("R7 no perr", perr, 0); eqc("R8 no ferr", ferr, 0);
    eqc("R9 irq", irq, 1);
    clr();
    eqc("R11 eot cleared", eot, 0); eqc("R11 sot cleared", sot, 0);
    eqc("R11 released", ps_clk_low, 4'h0);
  endtask

  task automatic t_parity();
    send(3, mkf(8'h3C, 1, 1), 0, 10);
    eqc("R7 perr", perr, 1); eqc("R7 data", rx_data, 8'h3C); eqc("R3 act_ch", act_ch, 3);
    clr();
  endtask

  task automatic t_stop_low();
    send(2, mkf(8'h81, 0, 0), 0, 10);
    eqc("R8 ferr", ferr, 1); eqc("R8 eot", eot, 1); eqc("R8 data", rx_data, 8'h81);
    eqc("R8 perr", perr, 0);
    clr();
  endtask

  task automatic t_tie();
    logic [10:0] f = mkf(8'h17, 0, 1);
    dev_dat[0] = 0; dev_dat[2] = 0; idle(H);
    dev_clk[0] = 0; dev_clk[2] = 0; idle(H);
    dev_clk[0] = 1; dev_clk[2] = 1; dev_dat[2] = 1;
    eqc("R5 lowest wins", act_ch, 0);
    eqc("R5 loser held", ps_clk_low, 4'b1110);
    send(0, f, 1, 10);
    eqc("R5 data", rx_data, 8'h17);
    clr();
  endtask

  task automatic t_first_wins();
    logic [10:0] f = mkf(8'hC3, 0, 1);
    send(3, f, 0, 0);
    dev_dat[0] = 0; idle(H);
    dev_clk[0] = 0; idle(H);
    dev_clk[0] = 1; dev_dat[0] = 1;
    eqc("R4 no takeover", act_ch, 3);
    send(3, f, 1, 10);
    eqc("R4 data", rx_data, 8'hC3); eqc("R4 act after", act_ch, 3);
    clr();
  endtask

  task automatic t_irq_mask();
    sot_ie = 0; eot_ie = 0;
    send(1, mkf(8'h01, 0, 1), 0, 10);
    eqc("R9 masked eot", eot, 1); eqc("R9 irq masked", irq, 0);
    sot_ie = 1; idle(3);
    eqc("R9 sot enable", irq, 1);
    clr(); eot_ie = 1;
  endtask

  task automatic t_glitch();
    dev_dat[0] = 0; idle(H);
    dev_clk[0] = 0; idle(2); dev_clk[0] = 1; idle(H);
    dev_dat[0] = 1;
    eqc("R10 glitch ignored", sot, 0);
  endtask

  task automatic t_abort();
    logic [10:0] f = mkf(8'h5A, 0, 1);
    send(1, f, 0, 3);
    ch_en = 4'h0; idle(4);
    eqc("R12 sot cleared", sot, 0); eqc("R12 all held", ps_clk_low, 4'hF);
    ch_en = 4'hF; idle(4);
    send(1, f, 0, 10);
    eqc("R12 recovered data", rx_data, 8'h5A);
    clr();
  endtask

  task automatic t_disabled();
    ch_en = 4'b0001; idle(4);
    send(2, mkf(8'h66, 0, 1), 0, 0);
    eqc("R13 ignored sot", sot, 0);
    eqc("R13 clk held", ps_clk_low, 4'b1110);
    ch_en = 4'hF; idle(4);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst = 0; idle(2);
    t_reset();
    t_enable();
    t_good_frame();
    t_parity();
    t_stop_low();
    t_tie();
    t_first_wins();
    t_irq_mask();
    t_glitch();
    t_abort();
    t_disabled();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule